// File: doc/BRIEF.md
# DRAM ECC Error Log Register Unit

This block sits beside a DRAM ECC checker and keeps a record of what that checker reports. Two strobes arrive from the checker. One marks a corrected single-bit error and the other an uncorrectable multi-bit error. Both share one information bus that carries a 33-bit physical address, a channel number and an 8-bit syndrome. Three more strobes report a refresh timeout, a locked access that targeted non-DRAM memory, and a thermal sensor event. Each strobe sets a sticky flag in a status register. Software clears a flag by writing 1 to it.

The unit logs the address, channel and syndrome of a single error. The log uses a 128-byte grain, so address bits 6:0 are never kept. A correctable error is logged only when no ECC flag is pending. An uncorrectable error always replaces the log, so the most serious event keeps its details. A command register enables, per cause, a system error output. The output is the OR of every flag that has its enable bit set.

All registers are reached through a plain register port. The port has a 3-bit word index, a write strobe, 16 bits of write data and a 32-bit read data bus that is combinational from the index.

Top module: `ecc_err_log`

## Requirements
- R1: Each strobe sets a status flag (word index 0) at the next clock edge. The flag positions are: bit 0 for a correctable error, bit 1 for an uncorrectable error, bit 8 for refresh timeout, bit 9 for non-DRAM lock, and bit 11 for thermal. All other status bits read 0.
- R2: A write to index 0 clears every flag whose write-data bit is 1. A flag whose write-data bit is 0 is left unchanged.
- R3: When a clear and a new event hit the same flag in the same cycle, the flag stays set.
- R4: Index 2 reads address bits 31:7 in bits 31:7 and the channel in bit 0. Bits 6:1 read 0, and address bits 6:0 are never stored.
- R5: Index 3 reads address bit 32 in bit 0. All its other bits read 0.
- R6: Index 4 reads the logged 8-bit syndrome in bits 7:0. All its other bits read 0.
- R7: A correctable error that arrives while status bits 0 and 1 are both clear loads the address, channel and syndrome.
- R8: A correctable error that arrives while status bit 0 or bit 1 is set leaves the log unchanged.
- R9: An uncorrectable error always loads the log. If both strobes arrive in one cycle, the log takes the shared bus values and both flags set.
- R10: The command register (index 1) is writable only in bits 0, 1, 8, 9 and 11. All its other bits read 0.
- R11: serr is the OR over all causes of (status flag AND command bit). It follows the registers in the same cycle.
- R12: Writes to indices 2 to 7 have no effect. Indices 5 to 7 read 0.
- R13: After reset every register reads 0 and serr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_valid | input | 1 | Correctable error strobe |
| ue_valid | input | 1 | Uncorrectable error strobe |
| err_addr | input | 33 | Physical address of the error |
| err_chan | input | 1 | Channel of the error |
| err_syn | input | 8 | ECC syndrome of the error |
| refresh_tmo | input | 1 | Refresh timeout strobe |
| lock_nondram | input | 1 | Lock to non-DRAM memory strobe |
| thermal_evt | input | 1 | Thermal sensor event strobe |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| serr | output | 1 | System error output |

## Verification
A wrong flag or enable bit shows up on serr and on the index-0 or index-1 readback in the first cycle after the edge that loaded it. A faulty log-load decision only shows when the log words are read. For that reason the bench reads every word and samples serr after each stimulus cycle. An extra correctable load or a missed uncorrectable load is then caught within one readback. Random traffic mixes clears with events so that the same-cycle precedence and the pending-flag guard are hit many times.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int STS_W   = 16;
    localparam int REG_W   = 32;
    localparam int PA_W    = 33;
    localparam int GRAIN   = 7;
    localparam int SYN_W   = 8;
    localparam int IDX_W   = 3;
    localparam int CAUSES  = 5;
    localparam int HI_W    = PA_W - GRAIN;

    localparam int BIT_CE    = 0;
    localparam int BIT_UE    = 1;
    localparam int BIT_RFTO  = 8;
    localparam int BIT_LOCK  = 9;
    localparam int BIT_THERM = 11;

    function automatic int cause_bit(input int i);
        case (i)
            0:       return BIT_CE;
            1:       return BIT_UE;
            2:       return BIT_RFTO;
            3:       return BIT_LOCK;
            default: return BIT_THERM;
        endcase
    endfunction

    function automatic logic [STS_W-1:0] cause_mask();
        logic [STS_W-1:0] m;
        m = '0;
        for (int i = 0; i < CAUSES; i++) m[cause_bit(i)] = 1'b1;
        return m;
    endfunction

    localparam logic [STS_W-1:0] CAUSE_MASK = cause_mask();

    typedef enum logic [IDX_W-1:0] {
        IDX_STS  = 3'd0,
        IDX_CMD  = 3'd1,
        IDX_PTR  = 3'd2,
        IDX_XPTR = 3'd3,
        IDX_SYN  = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic [HI_W-1:0]  addr_hi;
        logic             chan;
        logic [SYN_W-1:0] syn;
    } log_t;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic [STS_W-1:0] cmd;
    } ctl_t;

endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
    import ecc_log_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CAUSES-1:0]    cause_evt,
    input  logic [STS_W-1:0]     clr_mask,
    input  logic                 cmd_we,
    input  logic [STS_W-1:0]     cmd_wdata,
    output logic [STS_W-1:0]     sts,
    output logic [STS_W-1:0]     cmd,
    output logic                 serr
);

    ctl_t             ctl_d, ctl_q;
    logic [STS_W-1:0] evt_vec;

    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < CAUSES; i++) evt_vec[cause_bit(i)] = cause_evt[i];
    end

    always_comb begin
        ctl_d     = ctl_q;
        // a fresh event outranks a same-cycle clear
        ctl_d.sts = ((ctl_q.sts & ~clr_mask) | evt_vec) & CAUSE_MASK;
        if (cmd_we) ctl_d.cmd = cmd_wdata & CAUSE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sts  = ctl_q.sts;
    assign cmd  = ctl_q.cmd;
    assign serr = |(ctl_q.sts & ctl_q.cmd);

    AST_STS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sts & ~CAUSE_MASK) == '0); // R1
    AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd & ~CAUSE_MASK) == '0); // R10
    AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> (cmd != '0) && (sts != '0)); // R11

    for (genvar g = 0; g < CAUSES; g++) begin : g_cause
        localparam int P = cause_bit(g);
        AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            cause_evt[g] |=> sts[P]); // R1
        AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_evt[g] && clr_mask[P]) |=> sts[P]); // R3
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[P] && !cause_evt[g]) |=> !sts[P]); // R2
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_mask[P] && !cause_evt[g]) |=> sts[P] == $past(sts[P])); // R2
    end

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_valid,
    input  logic              ue_valid,
    input  logic [PA_W-1:0]   err_addr,
    input  logic              err_chan,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              ecc_busy,
    output log_t              log_q
);

    log_t log_d;
    logic take;
    logic unused_low_addr;

    assign unused_low_addr = ^err_addr[GRAIN-1:0];

    always_comb begin
        log_d = log_q;
        take  = ue_valid || (ce_valid && !ecc_busy);
        if (take) begin
            log_d.addr_hi = err_addr[PA_W-1:GRAIN];
            log_d.chan    = err_chan;
            log_d.syn     = err_syn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    AST_UE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ue_valid |=> (log_q.addr_hi == $past(err_addr[PA_W-1:GRAIN]))
                  && (log_q.syn == $past(err_syn)) && (log_q.chan == $past(err_chan))); // R9
    AST_CE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && !ue_valid && !ecc_busy) |=>
            (log_q.addr_hi == $past(err_addr[PA_W-1:GRAIN])) && (log_q.syn == $past(err_syn))); // R7
    AST_CE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_valid && !ue_valid && ecc_busy) |=> $stable(log_q)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_valid && !ue_valid) |=> $stable(log_q)); // R12

endmodule

// File: rtl/ecc_log_regport.sv
module ecc_log_regport
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic              reg_wr,
    input  logic [STS_W-1:0]  reg_wdata,
    input  logic [STS_W-1:0]  sts,
    input  logic [STS_W-1:0]  cmd,
    input  log_t              log_q,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [STS_W-1:0]  clr_mask,
    output logic              cmd_we,
    output logic [STS_W-1:0]  cmd_wdata
);

    localparam int LO_HI = REG_W - GRAIN;
    localparam int RSVD  = GRAIN - 1;

    always_comb begin
        clr_mask  = '0;
        cmd_we    = 1'b0;
        cmd_wdata = reg_wdata;
        if (reg_wr) begin
            case (reg_idx_e'(reg_addr))
                IDX_STS: clr_mask = reg_wdata & CAUSE_MASK;
                IDX_CMD: cmd_we   = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_idx_e'(reg_addr))
            IDX_STS:  reg_rdata = {{(REG_W-STS_W){1'b0}}, sts};
            IDX_CMD:  reg_rdata = {{(REG_W-STS_W){1'b0}}, cmd};
            IDX_PTR:  reg_rdata = {log_q.addr_hi[LO_HI-1:0], {RSVD{1'b0}}, log_q.chan};
            IDX_XPTR: reg_rdata = {{(REG_W-1){1'b0}}, log_q.addr_hi[HI_W-1]};
            IDX_SYN:  reg_rdata = {{(REG_W-SYN_W){1'b0}}, log_q.syn};
            default:  reg_rdata = '0;
        endcase
    end

    AST_PTR_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IDX_PTR) |-> reg_rdata[GRAIN-1:1] == '0); // R4
    AST_XPTR_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IDX_XPTR) |-> reg_rdata[REG_W-1:1] == '0); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > IDX_SYN) |-> reg_rdata == '0); // R12
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we && (clr_mask != '0))); // R12

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_valid,
    input  logic              ue_valid,
    input  logic [PA_W-1:0]   err_addr,
    input  logic              err_chan,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              refresh_tmo,
    input  logic              lock_nondram,
    input  logic              thermal_evt,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic              reg_wr,
    input  logic [STS_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              serr
);

    logic [STS_W-1:0]  sts, cmd, clr_mask, cmd_wdata;
    logic              cmd_we;
    logic [CAUSES-1:0] cause_evt;
    log_t              log_q;
    logic              ecc_busy;

    assign cause_evt = {thermal_evt, lock_nondram, refresh_tmo, ue_valid, ce_valid};
    assign ecc_busy  = sts[BIT_CE] | sts[BIT_UE];

    ecc_log_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_evt (cause_evt),
        .clr_mask  (clr_mask),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .sts       (sts),
        .cmd       (cmd),
        .serr      (serr)
    );

    ecc_log_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_valid (ce_valid),
        .ue_valid (ue_valid),
        .err_addr (err_addr),
        .err_chan (err_chan),
        .err_syn  (err_syn),
        .ecc_busy (ecc_busy),
        .log_q    (log_q)
    );

    ecc_log_regport u_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .sts       (sts),
        .cmd       (cmd),
        .log_q     (log_q),
        .reg_rdata (reg_rdata),
        .clr_mask  (clr_mask),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata)
    );

    AST_UE_FLAG_AFTER_UE: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_valid && ce_valid) |=> sts[BIT_UE] && sts[BIT_CE]); // R9

endmodule

// File: tb/ecc_err_log_bench.sv
`timescale 1ns/1ps
module ecc_err_log_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_valid, ue_valid, err_chan, refresh_tmo, lock_nondram, thermal_evt;
    logic [32:0] err_addr;
    logic [7:0]  err_syn;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        serr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_sts, m_cmd;
    logic [32:7] m_hi;
    logic        m_chan;
    logic [7:0]  m_syn;

    always #4 clk = ~clk;

    ecc_err_log u_ecc_err_log (
        .clk(clk), .rst_n(rst_n), .ce_valid(ce_valid), .ue_valid(ue_valid),
        .err_addr(err_addr), .err_chan(err_chan), .err_syn(err_syn),
        .refresh_tmo(refresh_tmo), .lock_nondram(lock_nondram), .thermal_evt(thermal_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr(serr)
    );

    task automatic idle();
        ce_valid = 0; ue_valid = 0; refresh_tmo = 0; lock_nondram = 0; thermal_evt = 0;
        reg_wr = 0; reg_wdata = '0; reg_addr = '0;
    endtask

    // model of the register unit, written from the requirements
    task automatic model_tick();
        logic [15:0] ev, clr, n_sts;
        logic        busy;
        ev  = '0;
        ev[0] = ce_valid; ev[1] = ue_valid; ev[8] = refresh_tmo;
        ev[9] = lock_nondram; ev[11] = thermal_evt;
        clr   = (reg_wr && reg_addr == 3'd0) ? reg_wdata : 16'h0;
        n_sts = ((m_sts & ~clr) | ev) & 16'h0B03;
        busy  = m_sts[0] | m_sts[1];
        if (reg_wr && reg_addr == 3'd1) m_cmd = reg_wdata & 16'h0B03;
        if (ue_valid || (ce_valid && !busy)) begin
            m_hi = err_addr[32:7]; m_chan = err_chan; m_syn = err_syn;
        end
        m_sts = n_sts;
    endtask

    task automatic tick();
        @(posedge clk);
        model_tick();
    endtask

    function automatic logic [31:0] exp_read(input int idx);
        case (idx)
            0: return {16'h0, m_sts};
            1: return {16'h0, m_cmd};
            2: return {m_hi[31:7], 6'b0, m_chan};
            3: return {31'b0, m_hi[32]};
            4: return {24'h0, m_syn};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_word(input int idx, output logic [31:0] v);
        @(negedge clk);
        idle();
        reg_addr = idx[2:0];
        #1 v = reg_rdata;
        @(posedge clk);
        model_tick();
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        @(negedge clk);
        idle();
        #1 chk({tag, " serr"}, {31'b0, serr}, {31'b0, |(m_sts & m_cmd)});
        for (int i = 0; i < 8; i++) begin
            read_word(i, v);
            chk($sformatf("%s word%0d", tag, i), v, exp_read(i));
        end
    endtask

    task automatic wr(input int idx, input logic [15:0] d);
        @(negedge clk);
        idle();
        reg_wr = 1; reg_addr = idx[2:0]; reg_wdata = d;
        tick();
    endtask

    task automatic ecc(input logic ce, input logic ue, input logic [32:0] a,
                       input logic ch, input logic [7:0] s);
        @(negedge clk);
        idle();
        ce_valid = ce; ue_valid = ue; err_addr = a; err_chan = ch; err_syn = s;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned sd;
        sd = $urandom(32'h1DEA5);
        idle();
        err_addr = '0; err_chan = 0; err_syn = '0;
        m_sts = '0; m_cmd = '0; m_hi = '0; m_chan = 0; m_syn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        check_all("R13 reset");

        // R7: first correctable error into an empty log
        ecc(1, 0, 33'h0_2345_67FF, 1, 8'hA5);
        read_word(2, v); chk("R4 ptr grain", v, 32'h2345_6781);
        read_word(4, v); chk("R6 syndrome", v, 32'h0000_00A5);
        check_all("R7");

        // R8: second correctable error is not logged
        ecc(1, 0, 33'h1_FFFF_FF80, 0, 8'h3C);
        read_word(4, v); chk("R8 syn kept", v, 32'h0000_00A5);
        check_all("R8");

        // R9: uncorrectable overwrites the earlier log
        ecc(0, 1, 33'h1_0000_0100, 0, 8'h5A);
        read_word(3, v); chk("R5 bit32", v, 32'h1);
        read_word(2, v); chk("R9 ptr", v, 32'h0000_0100);
        check_all("R9");

        // R2: zero write keeps, one write clears selected flag
        wr(0, 16'h0000);
        read_word(0, v); chk("R2 zero write", v, 32'h0003);
        wr(0, 16'h0001);
        read_word(0, v); chk("R2 w1c", v, 32'h0002);
        wr(0, 16'hFFFF);
        check_all("R2");

        // R3: clear and event in the same cycle
        @(negedge clk);
        idle();
        ce_valid = 1; err_addr = 33'h0_0000_0F00; err_syn = 8'h11;
        reg_wr = 1; reg_addr = 3'd0; reg_wdata = 16'hFFFF;
        tick();
        read_word(0, v); chk("R3 event wins", v, 32'h0001);
        check_all("R3");

        // R10 / R11: command mask and system error
        wr(1, 16'hFFFF);
        read_word(1, v); chk("R10 cmd mask", v, 32'h0B03);
        wr(0, 16'hFFFF);
        @(negedge clk); idle(); refresh_tmo = 1; tick();
        @(negedge clk); idle(); #1 chk("R11 serr rfto", {31'b0, serr}, 32'h1);
        @(negedge clk); idle(); lock_nondram = 1; thermal_evt = 1; tick();
        read_word(0, v); chk("R1 flags", v, 32'h0B00);
        wr(1, 16'h0000);
        @(negedge clk); idle(); #1 chk("R11 serr off", {31'b0, serr}, 32'h0);
        wr(1, 16'h0800);
        @(negedge clk); idle(); #1 chk("R11 serr thermal", {31'b0, serr}, 32'h1);
        check_all("R11");

        // R12: writes to read-only and unmapped words
        wr(2, 16'hFFFF); wr(3, 16'hFFFF); wr(4, 16'hFFFF); wr(6, 16'hFFFF);
        check_all("R12");

        // R9: both strobes together
        wr(0, 16'hFFFF);
        ecc(1, 1, 33'h0_8000_0000, 1, 8'hE7);
        read_word(0, v); chk("R9 both flags", v, 32'h0003);
        check_all("R9 both");

        // random mix
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            idle();
            ce_valid     = ($urandom % 3) == 0;
            ue_valid     = ($urandom % 7) == 0;
            refresh_tmo  = ($urandom % 9) == 0;
            lock_nondram = ($urandom % 9) == 0;
            thermal_evt  = ($urandom % 9) == 0;
            err_addr     = {$urandom, $urandom} & 33'h1_FFFF_FFFF;
            err_chan     = $urandom % 2;
            err_syn      = $urandom % 256;
            reg_wr       = ($urandom % 3) == 0;
            reg_addr     = ($urandom % 3 == 0) ? ($urandom % 8) : ($urandom % 2);
            reg_wdata    = $urandom % 65536;
            tick();
            if (n % 4 == 0) check_all("R1 R4 R5 R6 random");
            else begin
                @(negedge clk); idle(); #1
                chk("R11 random serr", {31'b0, serr}, {31'b0, |(m_sts & m_cmd)});
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule